// File: doc/BRIEF.md
# Frequency-Locked Supply Regulation Controller

This block is the digital heart of a supply-scaling loop. Software writes the clock rate it wants, in whole MHz, into a target register. The block counts rising edges of a ring-oscillator clock, whose rate follows the supply voltage, over fixed windows of the reference clock. At the end of each window it has a measurement in whole MHz. It subtracts that measurement from the target to get a signed error. From that error it drives two power-switch enables: `chg_en` adds charge to the supply capacitor and `dis_en` removes charge. A `track` flag tells whether the loop is still slewing.

The controller has two modes. In tracking it pushes the supply in whichever direction the error sign asks for. Once the error magnitude is below 4 MHz it settles into regulation. In regulation only the charge switch is used and the load pulls the supply down by itself. In both modes every measurement can start at most one pulse, and the pulse width scales with the error. Pulse width and pulse rate therefore both follow the error.

The sequencer has six states. TRK_HOLD waits for a measurement. TRK_DEAD is the idle gap used when the drive direction reverses. TRK_CHG and TRK_DIS each drive one pulse. REG_HOLD waits for a measurement in regulation, and REG_CHG drives a regulation pulse. The transitions are as follows:
- TRK_HOLD moves to REG_HOLD when the error is inside the band.
- TRK_HOLD moves to TRK_CHG or TRK_DIS when the drive keeps its direction, and to TRK_DEAD when the direction reverses.
- TRK_DEAD moves to the pending pulse state once the gap has elapsed.
- A pulse state returns to its hold state once its width is used up.
- REG_HOLD moves to REG_CHG when the error is positive.
- Any state moves to TRK_HOLD on a register write.

Top module: `freq_lock_ctrl`

## Requirements
- R1: After reset both enables are low, `track` is high and the target readback is 5.
- R2: A write stores the value clamped to the range 5..80. A value below 5 reads back as 5, a value above 80 reads back as 80, and values inside the range are stored unchanged.
- R3: Two clock cycles after a write is sampled, `track` is high, whatever mode was active before.
- R4: The measurement is the count of oscillator rising edges in one window of WIN_CYC reference cycles. A window of 1 µs makes the count equal to the rate in MHz, and the error is the target minus this count.
- R5: In tracking with a positive error, `chg_en` pulses and `dis_en` stays low.
- R6: In tracking with a negative error, `dis_en` pulses and `chg_en` stays low.
- R7: A measurement whose absolute error is below 4 moves the controller from tracking to regulation, and `track` falls.
- R8: In regulation `dis_en` never rises. `chg_en` pulses only after a measurement with positive error, and no pulse occurs when the error is zero or negative.
- R9: A pulse lasts min(|error| × GAIN, `max_pw`) reference cycles, with GAIN = 4. At most one pulse starts per measurement window, and no pulse exceeds the window-derived cap.
- R10: `chg_en` and `dis_en` are never high in the same cycle. When the drive direction reverses, at least DEAD_CYC (2) idle cycles separate the two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; it also times the measurement window |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Ring-oscillator clock whose rate is measured |
| wr_en | input | 1 | Write strobe for the target register |
| wr_mhz | input | 8 | Requested clock rate in MHz |
| max_pw | input | 8 | Programmable ceiling on pulse width, in reference cycles |
| tgt_mhz | output | 8 | Readback of the stored, clamped target |
| chg_en | output | 1 | Enable of the charge-delivering switch |
| dis_en | output | 1 | Enable of the charge-removing switch |
| track | output | 1 | High while in tracking mode |

## Verification
The bench builds the block with its defaults: a window of 250 cycles, GAIN 4 and a 2-cycle dead gap. At the 4 ns bench clock this window is exactly 1 µs, so the edge count equals the oscillator rate in MHz. The oscillator periods are integer nanosecond multiples with a fixed sub-nanosecond phase offset, which makes every measurement exact and each pulse width predictable to the cycle. Driving `max_pw` at 100 and then 30 shows both the proportional region and the ceiling. A final closed-loop phase with a leaking charge model shows the walk from tracking into regulation.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;

    typedef enum logic [2:0] {
        S_TRK_HOLD = 3'd0,
        S_TRK_DEAD = 3'd1,
        S_TRK_CHG  = 3'd2,
        S_TRK_DIS  = 3'd3,
        S_REG_HOLD = 3'd4,
        S_REG_CHG  = 3'd5
    } flc_state_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } flc_dir_e;

endpackage

// File: rtl/flc_target_reg.sv
`timescale 1ns/1ps
module flc_target_reg #(
    parameter int MHZ_W = 8,
    parameter int F_MIN = 5,
    parameter int F_MAX = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [MHZ_W-1:0] wr_mhz,
    output logic [MHZ_W-1:0] target,
    output logic             new_req
);

    localparam logic [MHZ_W-1:0] LO = MHZ_W'(F_MIN);
    localparam logic [MHZ_W-1:0] HI = MHZ_W'(F_MAX);

    logic [MHZ_W-1:0] clamped;

    always_comb begin
        if (wr_mhz < LO)      clamped = LO;
        else if (wr_mhz > HI) clamped = HI;
        else                  clamped = wr_mhz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target  <= LO;
            new_req <= 1'b0;
        end else begin
            new_req <= wr_en;
            if (wr_en) target <= clamped;
        end
    end

endmodule

// File: rtl/flc_freq_meter.sv
`timescale 1ns/1ps
module flc_freq_meter #(
    parameter int CNT_W    = 10,
    parameter int MHZ_W    = 8,
    parameter int WIN_CYC  = 250,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_clk,
    output logic [MHZ_W-1:0] meas_mhz,
    output logic             meas_vld
);

    localparam int WIN_W = $clog2(WIN_CYC);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] SAT = CNT_W'((1 << MHZ_W) - 1);

    function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        for (int i = 0; i < CNT_W; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    // oscillator domain: binary edge counter with a registered Gray copy
    logic [CNT_W-1:0] osc_bin, osc_gray, osc_inc;
    assign osc_inc = osc_bin + 1'b1;

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_bin  <= '0;
            osc_gray <= '0;
        end else begin
            osc_bin  <= osc_inc;
            osc_gray <= osc_inc ^ (osc_inc >> 1);
        end
    end

    // reference domain: flop chain, one stage per generate iteration
    logic [CNT_W-1:0] sync_q [SYNC_STG];

    for (genvar s = 0; s < SYNC_STG; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sync_q[s] <= '0;
            else if (s == 0) sync_q[s] <= osc_gray;
            else             sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
        end
    end

    logic [CNT_W-1:0] cur_bin, snap, delta;
    logic [WIN_W-1:0] win_cnt;
    logic             primed, win_end;

    assign cur_bin = gray_to_bin(sync_q[SYNC_STG-1]);
    assign delta   = cur_bin - snap;
    assign win_end = (win_cnt == WIN_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            snap     <= '0;
            primed   <= 1'b0;
            meas_mhz <= '0;
            meas_vld <= 1'b0;
        end else begin
            meas_vld <= 1'b0;
            if (win_end) begin
                win_cnt <= '0;
                snap    <= cur_bin;
                primed  <= 1'b1;
                if (primed) begin
                    meas_mhz <= (delta > SAT) ? MHZ_W'(SAT) : MHZ_W'(delta);
                    meas_vld <= 1'b1;
                end
            end else begin
                win_cnt <= win_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flc_pulse_fsm.sv
`timescale 1ns/1ps
module flc_pulse_fsm
    import flc_pkg::*;
#(
    parameter int MHZ_W     = 8,
    parameter int PW_W      = 8,
    parameter int GAIN      = 4,
    parameter int DEAD_CYC  = 2,
    parameter int PW_CAP    = 245,
    parameter int LOCK_BAND = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_req,
    input  logic [MHZ_W-1:0] target,
    input  logic [MHZ_W-1:0] meas_mhz,
    input  logic             meas_vld,
    input  logic [PW_W-1:0]  max_pw,
    output logic             chg_en,
    output logic             dis_en,
    output logic             track
);

    localparam int RAW_W  = MHZ_W + 1 + $clog2(GAIN + 1);
    localparam int PROD_W = (RAW_W > PW_W) ? RAW_W : PW_W + 1;
    localparam int DC_W   = $clog2(DEAD_CYC + 1);
    localparam logic [PW_W-1:0]  CAP  = PW_W'(PW_CAP);
    localparam logic [MHZ_W:0]   BAND = (MHZ_W + 1)'(LOCK_BAND);

    flc_state_e state, nxt;
    flc_dir_e   last_dir, pend_dir, want_dir;

    logic signed [MHZ_W:0] err;
    logic [MHZ_W:0]        err_abs;
    logic                  err_pos, in_band, reversal;
    logic [PROD_W-1:0]     prod;
    logic [PW_W-1:0]       lim, pw_calc, pw_cnt;
    logic [DC_W-1:0]       dead_cnt;

    // error and width datapath
    always_comb begin
        err      = $signed({1'b0, target}) - $signed({1'b0, meas_mhz});
        err_abs  = err[MHZ_W] ? $unsigned(-err) : $unsigned(err);
        err_pos  = !err[MHZ_W] && (err != '0);
        in_band  = (err_abs < BAND);
        prod     = PROD_W'(err_abs) * PROD_W'(GAIN);
        lim      = (max_pw < CAP) ? max_pw : CAP;
        pw_calc  = (prod > PROD_W'(lim)) ? lim : PW_W'(prod);
        want_dir = err_pos ? DIR_UP : DIR_DN;
        reversal = (last_dir != DIR_NONE) && (last_dir != want_dir);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_TRK_HOLD;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (new_req) begin
            nxt = S_TRK_HOLD;
        end else begin
            unique case (state)
                S_TRK_HOLD: begin
                    if (meas_vld) begin
                        if (in_band)              nxt = S_REG_HOLD;
                        else if (pw_calc != '0) begin
                            if (reversal)         nxt = S_TRK_DEAD;
                            else if (err_pos)     nxt = S_TRK_CHG;
                            else                  nxt = S_TRK_DIS;
                        end
                    end
                end
                S_TRK_DEAD: begin
                    if (dead_cnt == DC_W'(1))
                        nxt = (pend_dir == DIR_UP) ? S_TRK_CHG : S_TRK_DIS;
                end
                S_TRK_CHG, S_TRK_DIS: begin
                    if (pw_cnt == PW_W'(1)) nxt = S_TRK_HOLD;
                end
                S_REG_HOLD: begin
                    if (meas_vld && err_pos && (pw_calc != '0)) nxt = S_REG_CHG;
                end
                S_REG_CHG: begin
                    if (pw_cnt == PW_W'(1)) nxt = S_REG_HOLD;
                end
                default: nxt = S_TRK_HOLD;
            endcase
        end
    end

    // counters and direction memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_cnt   <= '0;
            dead_cnt <= '0;
            last_dir <= DIR_NONE;
            pend_dir <= DIR_NONE;
        end else begin
            if (meas_vld && (state == S_TRK_HOLD || state == S_REG_HOLD)) begin
                pw_cnt   <= pw_calc;
                pend_dir <= want_dir;
            end else if (state == S_TRK_CHG || state == S_TRK_DIS || state == S_REG_CHG) begin
                pw_cnt <= pw_cnt - 1'b1;
            end

            if (state != S_TRK_DEAD && nxt == S_TRK_DEAD) dead_cnt <= DC_W'(DEAD_CYC);
            else if (state == S_TRK_DEAD)                 dead_cnt <= dead_cnt - 1'b1;

            if (state == S_TRK_CHG || state == S_REG_CHG) last_dir <= DIR_UP;
            else if (state == S_TRK_DIS)                  last_dir <= DIR_DN;
        end
    end

    // outputs
    always_comb begin
        chg_en = 1'b0;
        dis_en = 1'b0;
        track  = 1'b0;
        unique case (state)
            S_TRK_HOLD, S_TRK_DEAD: track = 1'b1;
            S_TRK_CHG: begin track = 1'b1; chg_en = 1'b1; end
            S_TRK_DIS: begin track = 1'b1; dis_en = 1'b1; end
            S_REG_HOLD: ;
            S_REG_CHG: chg_en = 1'b1;
            default: track = 1'b1;
        endcase
    end

endmodule

// File: rtl/freq_lock_ctrl.sv
`timescale 1ns/1ps
module freq_lock_ctrl #(
    parameter int MHZ_W     = 8,
    parameter int CNT_W     = 10,
    parameter int WIN_CYC   = 250,
    parameter int SYNC_STG  = 2,
    parameter int F_MIN     = 5,
    parameter int F_MAX     = 80,
    parameter int GAIN      = 4,
    parameter int DEAD_CYC  = 2,
    parameter int PW_W      = 8,
    parameter int LOCK_BAND = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_clk,
    input  logic             wr_en,
    input  logic [MHZ_W-1:0] wr_mhz,
    input  logic [PW_W-1:0]  max_pw,
    output logic [MHZ_W-1:0] tgt_mhz,
    output logic             chg_en,
    output logic             dis_en,
    output logic             track
);

    localparam int WIN_ROOM = WIN_CYC - DEAD_CYC - 3;
    localparam int PW_TOP   = (1 << PW_W) - 1;
    localparam int PW_CAP   = (WIN_ROOM < PW_TOP) ? WIN_ROOM : PW_TOP;

    logic             new_req, meas_vld;
    logic [MHZ_W-1:0] meas_mhz;

    flc_target_reg #(.MHZ_W(MHZ_W), .F_MIN(F_MIN), .F_MAX(F_MAX)) u_tgt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mhz(wr_mhz),
        .target(tgt_mhz), .new_req(new_req)
    );

    flc_freq_meter #(.CNT_W(CNT_W), .MHZ_W(MHZ_W), .WIN_CYC(WIN_CYC), .SYNC_STG(SYNC_STG)) u_meter (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk),
        .meas_mhz(meas_mhz), .meas_vld(meas_vld)
    );

    flc_pulse_fsm #(
        .MHZ_W(MHZ_W), .PW_W(PW_W), .GAIN(GAIN), .DEAD_CYC(DEAD_CYC),
        .PW_CAP(PW_CAP), .LOCK_BAND(LOCK_BAND)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .new_req(new_req), .target(tgt_mhz),
        .meas_mhz(meas_mhz), .meas_vld(meas_vld), .max_pw(max_pw),
        .chg_en(chg_en), .dis_en(dis_en), .track(track)
    );

endmodule

// File: rtl/flc_checker.sv
`timescale 1ns/1ps
module flc_checker #(
    parameter int MHZ_W    = 8,
    parameter int F_MIN    = 5,
    parameter int F_MAX    = 80,
    parameter int DEAD_CYC = 2,
    parameter int PW_CAP   = 245
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [MHZ_W-1:0] tgt_mhz,
    input logic             chg_en,
    input logic             dis_en,
    input logic             track
);

    logic [8:0] chg_run, dis_run;
    logic [7:0] since_chg, since_dis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_run   <= '0;
            dis_run   <= '0;
            since_chg <= 8'hFF;
            since_dis <= 8'hFF;
        end else begin
            chg_run   <= chg_en ? chg_run + 1'b1 : '0;
            dis_run   <= dis_en ? dis_run + 1'b1 : '0;
            since_chg <= chg_en ? '0 : ((since_chg == 8'hFF) ? since_chg : since_chg + 1'b1);
            since_dis <= dis_en ? '0 : ((since_dis == 8'hFF) ? since_dis : since_dis + 1'b1);
        end
    end

    AST_TARGET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_mhz >= MHZ_W'(F_MIN)) && (tgt_mhz <= MHZ_W'(F_MAX))); // R2

    AST_WRITE_FORCES_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ##2 track); // R3

    AST_REG_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !track |-> !dis_en); // R8

    AST_CHG_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en |-> (chg_run < 9'(PW_CAP))); // R9

    AST_DIS_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        dis_en |-> (dis_run < 9'(PW_CAP))); // R9

    AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_en && dis_en)); // R10

    AST_DEAD_BEFORE_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_en) |-> (since_chg >= 8'(DEAD_CYC))); // R10

    AST_DEAD_BEFORE_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_en) |-> (since_dis >= 8'(DEAD_CYC))); // R10

endmodule

bind freq_lock_ctrl flc_checker #(
    .MHZ_W(MHZ_W), .F_MIN(F_MIN), .F_MAX(F_MAX), .DEAD_CYC(DEAD_CYC), .PW_CAP(PW_CAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tgt_mhz(tgt_mhz),
    .chg_en(chg_en), .dis_en(dis_en), .track(track)
);

// File: tb/freq_lock_ctrl_bench.sv
`timescale 1ns/1ps
module freq_lock_ctrl_bench;

    localparam int WIN = 250;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_mhz = 8'd0;
    logic [7:0] max_pw = 8'd100;
    logic [7:0] tgt_mhz;
    logic       chg_en, dis_en, track;

    int n_run = 0;
    int n_fail = 0;

    freq_lock_ctrl u_freq_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc), .wr_en(wr_en), .wr_mhz(wr_mhz),
        .max_pw(max_pw), .tgt_mhz(tgt_mhz), .chg_en(chg_en), .dis_en(dis_en), .track(track)
    );

    always #2 clk = ~clk;

    // behavioural supply: frozen rate or charge model with a constant load
    real f_set = 20.0;
    real f_dyn = 20.0;
    bit  plant_dyn = 1'b0;

    initial begin
        #0.3;
        forever begin
            #(500.0 / (plant_dyn ? f_dyn : f_set));
            osc = ~osc;
        end
    end

    always @(posedge clk) begin
        real nf;
        if (!plant_dyn) nf = f_set;
        else begin
            nf = f_dyn - 0.002;
            if (chg_en) nf = nf + 0.05;
            if (dis_en) nf = nf - 0.05;
            if (nf < 2.0) nf = 2.0;
        end
        f_dyn <= nf;
    end

    // pulse monitor
    int chg_run = 0, dis_run = 0, chg_cnt = 0, dis_cnt = 0;
    int last_chg_w = 0, last_dis_w = 0;
    int since_chg = 1000, since_dis = 1000, min_rev_gap = 1000;
    bit both_hi = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (chg_en && dis_en) both_hi = 1'b1;
            if (chg_en) begin
                if (chg_run == 0 && since_dis < min_rev_gap) min_rev_gap = since_dis;
                chg_run++;
            end
            if (dis_en) begin
                if (dis_run == 0 && since_chg < min_rev_gap) min_rev_gap = since_chg;
                dis_run++;
            end
            if (chg_en) since_chg = 0;
            else begin
                if (chg_run > 0) begin last_chg_w = chg_run; chg_cnt++; end
                chg_run = 0;
                if (since_chg < 1000) since_chg++;
            end
            if (dis_en) since_dis = 0;
            else begin
                if (dis_run > 0) begin last_dis_w = dis_run; dis_cnt++; end
                dis_run = 0;
                if (since_dis < 1000) since_dis++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int v);
        wr_en  = 1'b1;
        wr_mhz = 8'(v);
        cyc(1);
        wr_en  = 1'b0;
    endtask

    task automatic t_reset;
        cyc(2);
        chk(chg_en == 1'b0, "R1 chg_en after reset", int'(chg_en), 0);
        chk(dis_en == 1'b0, "R1 dis_en after reset", int'(dis_en), 0);
        chk(track == 1'b1, "R1 track after reset", int'(track), 1);
        chk(tgt_mhz == 8'd5, "R1 target after reset", int'(tgt_mhz), 5);
    endtask

    task automatic t_clamp;
        int vals[6] = '{2, 200, 80, 5, 0, 37};
        int exps[6] = '{5, 80, 80, 5, 5, 37};
        foreach (vals[i]) begin
            wr(vals[i]);
            chk(int'(tgt_mhz) == exps[i], "R2 clamped readback", int'(tgt_mhz), exps[i]);
        end
    endtask

    // rate 20, target 22: error 2, regulation pulses of 8 cycles
    task automatic t_reg_up;
        int c0, d0;
        f_set = 20.0;
        wr(22);
        cyc(4 * WIN);
        c0 = chg_cnt; d0 = dis_cnt;
        cyc(3 * WIN);
        chk(track == 1'b0, "R7 in band leaves tracking", int'(track), 0);
        chk(chg_cnt - c0 >= 2, "R8 regulation pulses on positive error", chg_cnt - c0, 2);
        chk(chg_cnt - c0 <= 3, "R9 at most one pulse per window", chg_cnt - c0, 3);
        chk(dis_cnt == d0, "R8 no drain in regulation", dis_cnt - d0, 0);
        chk(last_chg_w == 8, "R4 R9 width from measured error", last_chg_w, 8);
    endtask

    // negative and zero error in regulation: nothing fires
    task automatic t_reg_skip;
        int c0, d0;
        wr(18);
        cyc(1);
        chk(track == 1'b1, "R3 write forces tracking", int'(track), 1);
        cyc(4 * WIN);
        c0 = chg_cnt; d0 = dis_cnt;
        cyc(3 * WIN);
        chk(track == 1'b0, "R7 negative in-band error regulates", int'(track), 0);
        chk(chg_cnt == c0, "R8 no pulse on negative error", chg_cnt - c0, 0);
        chk(dis_cnt == d0, "R8 drain stays low", dis_cnt - d0, 0);
        wr(20);
        cyc(4 * WIN);
        c0 = chg_cnt;
        cyc(3 * WIN);
        chk(chg_cnt == c0, "R8 no pulse on zero error", chg_cnt - c0, 0);
    endtask

    task automatic t_trk_up;
        int c0, d0;
        wr(60);
        cyc(3 * WIN);
        c0 = chg_cnt; d0 = dis_cnt;
        cyc(3 * WIN);
        chk(track == 1'b1, "R5 large error keeps tracking", int'(track), 1);
        chk(chg_cnt - c0 >= 2, "R5 charge pulses", chg_cnt - c0, 2);
        chk(dis_cnt == d0, "R5 drain low on positive error", dis_cnt - d0, 0);
        chk(last_chg_w == 100, "R9 width capped by max_pw", last_chg_w, 100);
        max_pw = 8'd30;
        cyc(2 * WIN);
        chk(last_chg_w == 30, "R9 lower max_pw cap", last_chg_w, 30);
        max_pw = 8'd100;
        wr(27);
        cyc(3 * WIN);
        chk(last_chg_w == 28, "R9 width proportional in tracking", last_chg_w, 28);
    endtask

    task automatic t_trk_down;
        int c0;
        f_set = 40.0;
        wr(10);
        cyc(3 * WIN);
        c0 = chg_cnt;
        cyc(3 * WIN);
        chk(track == 1'b1, "R6 tracking on negative error", int'(track), 1);
        chk(last_dis_w == 100, "R6 R9 drain pulse width", last_dis_w, 100);
        chk(chg_cnt == c0, "R6 charge low on negative error", chg_cnt - c0, 0);
        chk(min_rev_gap >= 2, "R10 dead gap on reversal", min_rev_gap, 2);
        chk(both_hi == 1'b0, "R10 enables never together", int'(both_hi), 0);
    endtask

    task automatic t_closed_loop;
        int c0, d0, fi;
        f_set = 20.0;
        cyc(2);
        plant_dyn = 1'b1;
        wr(50);
        for (int i = 0; i < 40; i++) begin
            cyc(WIN);
            if (!track) break;
        end
        chk(track == 1'b0, "R7 loop reaches regulation", int'(track), 0);
        cyc(2 * WIN);
        c0 = chg_cnt; d0 = dis_cnt;
        cyc(4 * WIN);
        fi = $rtoi(f_dyn + 0.5);
        chk(dis_cnt == d0, "R8 load alone lowers supply", dis_cnt - d0, 0);
        chk(chg_cnt - c0 >= 1, "R8 regulation replaces lost charge", chg_cnt - c0, 1);
        chk(fi >= 45 && fi <= 55, "R7 settled rate near target", fi, 50);
        chk(both_hi == 1'b0, "R10 exclusive through closed loop", int'(both_hi), 0);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        t_reset();
        t_clamp();
        t_reg_up();
        t_reg_skip();
        t_trk_up();
        t_trk_down();
        t_closed_loop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule